// File: doc/BRIEF.md
# Gated Snapshot Frequency Counter

The block measures the frequency of a fast signal by sampling a free-running counter at fixed intervals. A counter clocked by the measured signal counts without ever being cleared. A slow gate is made from a separate reference clock by a divider. On every rising edge of that gate, the current count is copied into a holding register and a ready flag is raised. The host subtracts successive snapshots modulo the counter width, which gives the number of measured edges per gate period. With a 10 MHz reference and the default divider, that is the frequency divided by 1000.

Two measured inputs and two reference inputs are each chosen by a static select. A select is only changed while results are being discarded. The gate crosses into the measured domain through a two-flop synchronizer. The host acknowledge crosses the same way. The acknowledge is edge-detected and then clears the ready flag. The block handles measured rates from 10 kHz up to 200 MHz.

Top module: `fc_snapshot_core`

## Requirements
- R1: The count is CNT_W bits wide (default 20). It rises by one on every rising edge of the selected measured clock and wraps modulo 2^CNT_W. A capture does not clear it.
- R2: With `meas_sel_i` = 0 the measured clock is `meas_a_i`. With `meas_sel_i` = 1 it is `meas_b_i`.
- R3: With `ref_sel_i` = 0 the reference is `ref_a_i`. With `ref_sel_i` = 1 it is `ref_b_i`. The gate toggles once every DIV_MAX+1 reference cycles (default 5000), so one gate period is 2*(DIV_MAX+1) reference cycles.
- R4: Two successive snapshots differ, modulo 2^CNT_W, by the number of measured edges in one gate period, within ±1.
- R5: `snap_o` changes only on a capture. A capture happens once per gate rising edge: the gate is resynchronized by two flops, its edge is detected, and the result is registered one more cycle. Between captures `snap_o` holds its value.
- R6: `ready_o` goes high on the same measured-clock edge that loads `snap_o`.
- R7: A rising edge on `rd_ack_i` clears `ready_o` on the second measured-clock edge after it. Holding `rd_ack_i` high, or a falling edge, does not clear the flag.
- R8: When a capture and a clear fall on the same edge, `ready_o` ends high.
- R9: While `rst_ni` is low, `snap_o` and `ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| meas_a_i | input | 1 | Measured signal, direct path |
| meas_b_i | input | 1 | Measured signal, prescaled path |
| meas_sel_i | input | 1 | Static measured-clock select |
| ref_a_i | input | 1 | Reference clock, first source |
| ref_b_i | input | 1 | Reference clock, second source |
| ref_sel_i | input | 1 | Static reference select |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_ack_i | input | 1 | Host read acknowledge, asynchronous |
| snap_o | output | CNT_W | Held snapshot of the count |
| ready_o | output | 1 | Snapshot available flag |

## Verification
A capture setting the ready flag and a synchronized acknowledge clearing it can fall on the same measured-clock edge. The bench first finds the exact spacing of captures, which is a whole number of measured cycles. It then raises the acknowledge at a sweep of offsets before the next expected capture. One of those offsets lands the clear pulse on the capture edge. At every observed snapshot change the flag must read high. A design where the clear takes priority shows a low flag at that one offset.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned DefCntW   = 20;
  localparam int unsigned DefDivMax = 4999;
  localparam int unsigned DefSyncN  = 2;
endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge #(
  parameter int unsigned STAGES = fc_pkg::DefSyncN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned Last = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], async_i};
  end

  // edge taken between the last two stages of the chain
  assign rise_o = sync_q[Last-1] & ~sync_q[Last];

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fc_gate_div.sv
module fc_gate_div #(
  parameter int unsigned DIV_MAX = fc_pkg::DefDivMax
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_o
);
  localparam int unsigned DivW = $clog2(DIV_MAX + 1);
  localparam logic [DivW-1:0] DivTop = DivW'(DIV_MAX);

  logic [DivW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      gate_o <= 1'b0;
    end else if (div_q >= DivTop) begin
      div_q  <= '0;
      gate_o <= ~gate_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  a_r3_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DivTop);
  a_r3_gate_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_o) |-> ($past(div_q) == DivTop));
endmodule

// File: rtl/fc_capture.sv
module fc_capture #(
  parameter int unsigned CNT_W = fc_pkg::DefCntW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_rise_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cap_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      cap_en_q <= 1'b0;
      snap_o   <= '0;
      ready_o  <= 1'b0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      cap_en_q <= gate_rise_i;
      if (cap_en_q) snap_o <= cnt_q;
      // set has priority over clear
      if (cap_en_q)   ready_o <= 1'b1;
      else if (clr_i) ready_o <= 1'b0;
    end
  end

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '0));
  a_r5_snap_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(snap_o) |-> $past(cap_en_q));
  a_r6_ready_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_q |=> ready_o);
  a_r7_ready_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_en_q) |=> !ready_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && cap_en_q) |=> ready_o);
endmodule

// File: rtl/fc_snapshot_core.sv
module fc_snapshot_core #(
  parameter int unsigned CNT_W   = fc_pkg::DefCntW,
  parameter int unsigned DIV_MAX = fc_pkg::DefDivMax,
  parameter int unsigned SYNC_N  = fc_pkg::DefSyncN
) (
  input  logic             meas_a_i,
  input  logic             meas_b_i,
  input  logic             meas_sel_i,
  input  logic             ref_a_i,
  input  logic             ref_b_i,
  input  logic             ref_sel_i,
  input  logic             rst_ni,
  input  logic             rd_ack_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             ready_o
);
  logic meas_clk, ref_clk;
  logic gate, gate_rise, ack_rise;

  // static selects, changed only while results are discarded
  assign meas_clk = meas_sel_i ? meas_b_i : meas_a_i;
  assign ref_clk  = ref_sel_i  ? ref_b_i  : ref_a_i;

  fc_gate_div #(.DIV_MAX(DIV_MAX)) u_gate_div (
    .clk_i (ref_clk),
    .rst_ni(rst_ni),
    .gate_o(gate)
  );

  fc_sync_edge #(.STAGES(SYNC_N)) u_gate_sync (
    .clk_i  (meas_clk),
    .rst_ni (rst_ni),
    .async_i(gate),
    .rise_o (gate_rise)
  );

  fc_sync_edge #(.STAGES(SYNC_N)) u_ack_sync (
    .clk_i  (meas_clk),
    .rst_ni (rst_ni),
    .async_i(rd_ack_i),
    .rise_o (ack_rise)
  );

  fc_capture #(.CNT_W(CNT_W)) u_capture (
    .clk_i      (meas_clk),
    .rst_ni     (rst_ni),
    .gate_rise_i(gate_rise),
    .clr_i      (ack_rise),
    .snap_o     (snap_o),
    .ready_o    (ready_o)
  );
endmodule

// File: tb/fc_snapshot_core_bench.sv
`timescale 1ns/1ps
module fc_snapshot_core_bench;
  localparam int CLK_PERIOD = 10;   // ref_a period, ns
  localparam int REF_B_PER  = 8;
  localparam int MEAS_A_PER = 4;
  localparam int MEAS_B_PER = 10;
  localparam int CNT_W      = 10;
  localparam int DIV_MAX    = 49;
  localparam int MOD        = 1 << CNT_W;

  logic meas_a = 0, meas_b = 0, ref_a = 0, ref_b = 0;
  logic meas_sel = 0, ref_sel = 0, rst_n = 0, rd_ack = 0;
  logic [CNT_W-1:0] snap;
  logic ready;
  logic mclk;
  int checks = 0, errors = 0;

  always #(MEAS_A_PER/2) meas_a = ~meas_a;
  always #(MEAS_B_PER/2) meas_b = ~meas_b;
  always #(CLK_PERIOD/2) ref_a  = ~ref_a;
  always #(REF_B_PER/2)  ref_b  = ~ref_b;
  assign mclk = meas_sel ? meas_b : meas_a;

  fc_snapshot_core #(.CNT_W(CNT_W), .DIV_MAX(DIV_MAX)) u_fc_snapshot_core (
    .meas_a_i(meas_a), .meas_b_i(meas_b), .meas_sel_i(meas_sel),
    .ref_a_i(ref_a), .ref_b_i(ref_b), .ref_sel_i(ref_sel),
    .rst_ni(rst_n), .rd_ack_i(rd_ack), .snap_o(snap), .ready_o(ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mdiff(input int a, input int b);
    return (b - a + MOD) % MOD;
  endfunction

  // polls at falling edges until snap changes; returns ready seen at that sample
  task automatic wait_capture(output int val, output bit rdy);
    int prev = int'(snap);
    val = prev; rdy = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge mclk);
      if (int'(snap) != prev) begin
        val = int'(snap); rdy = ready;
        return;
      end
    end
    chk(0, "R5 capture timeout", prev, -1);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge meas_a);
    chk(snap == 0, "R9 snap in reset", int'(snap), 0);
    chk(ready == 0, "R9 ready in reset", int'(ready), 0);
    rst_n = 1;
    @(negedge meas_a);
    chk(snap == 0, "R9 snap after release", int'(snap), 0);
  endtask

  // R4 difference test; also tracks wrap for R1
  task automatic t_diff(input string req, input int exp, input int n, input bit need_wrap);
    int a, b; bit r; bit wrapped = 0;
    wait_capture(a, r);
    wait_capture(a, r);  // discard after select change
    for (int i = 0; i < n; i++) begin
      wait_capture(b, r);
      chk(mdiff(a, b) >= exp - 1 && mdiff(a, b) <= exp + 1, req, mdiff(a, b), exp);
      if (b < a) wrapped = 1;
      a = b;
    end
    if (need_wrap) chk(wrapped, "R1 counter wrapped", int'(wrapped), 1);
  endtask

  task automatic t_hold();
    int v; bit r; bit stable = 1;
    wait_capture(v, r);
    chk(r == 1, "R6 ready with capture", int'(r), 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge mclk);
      if (int'(snap) != v) stable = 0;
    end
    chk(stable, "R5 snap held between captures", int'(snap), v);
  endtask

  task automatic t_clear();
    int v; bit r;
    wait_capture(v, r);
    rd_ack = 1;
    @(negedge mclk);
    chk(ready == 1, "R7 no clear after one edge", int'(ready), 1);
    @(negedge mclk);
    chk(ready == 0, "R7 cleared on second edge", int'(ready), 0);
    // held high: next capture must stay set
    wait_capture(v, r);
    repeat (20) @(negedge mclk);
    chk(ready == 1, "R7 level ack no clear", int'(ready), 1);
    rd_ack = 0;
    repeat (20) @(negedge mclk);
    chk(ready == 1, "R7 falling ack no clear", int'(ready), 1);
  endtask

  task automatic t_collide();
    int v; bit r;
    int per = 1000 / MEAS_A_PER;  // captures per gate period in meas cycles
    for (int m = per - 4; m <= per; m++) begin
      rd_ack = 0;
      wait_capture(v, r);
      repeat (m) @(negedge mclk);
      rd_ack = 1;
      wait_capture(v, r);
      chk(r == 1, "R8 set wins at capture", int'(r), 1);
    end
    rd_ack = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    // R2/R4: meas_a 4 ns over 1000 ns gate -> 250
    t_diff("R4 diff meas_a", 1000 / MEAS_A_PER, 6, 1);
    t_hold();
    t_clear();
    t_collide();
    // R2: meas_b 10 ns -> 100
    meas_sel = 1;
    t_diff("R2 diff meas_b", 1000 / MEAS_B_PER, 3, 0);
    meas_sel = 0;
    // R3: ref_b 8 ns -> gate 800 ns -> 200
    ref_sel = 1;
    t_diff("R3 diff ref_b", 2 * (DIV_MAX + 1) * REF_B_PER / MEAS_A_PER, 3, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule